// File: doc/BRIEF.md
# Byte-Level I2C Master with Status-Code Handshake

This block drives an I2C bus as a single master, one byte at a time. A host loads a byte into the shift/data register and writes the control bits (start request, stop request, acknowledge enable). Each write of the control bits clears the interrupt flag and launches one bus action. When the action finishes, the engine raises the interrupt flag and publishes an 8-bit status code that names the event. Those events are START, repeated START, address or data byte with the acknowledge seen, lost arbitration, and stuck lines. While the flag is up, the engine holds SCL low, so the host can take as long as it likes to answer.

A STOP completes without raising the flag. The code then falls back to the idle value. The SCL low and high phases last the programmed number of clock cycles. A line that stays low longer than a fixed timeout ends the action with a fault code, and both lines are released.

Top module: `i2c_status_master`

## Requirements
- R1: After reset the status is 0xF8, the interrupt flag is 0 and neither line is driven.
- R2: A control write with the start bit from idle sends a START, then reports 0x08 with the flag set. While the flag is set after a normal event, SCL is held low, and a control write clears the flag in the next cycle.
- R3: The address byte is shifted out MSB first and carries the read/write bit in bit 0 (1 = read). With bit 0 = 0 the status is 0x18 if the slave acknowledges and 0x20 if it does not.
- R4: After a transmitted data byte the status is 0x28 on ACK and 0x30 on NACK.
- R5: With address bit 0 = 1 the status is 0x40 on ACK and 0x48 on NACK.
- R6: A received byte is readable on the data output. The acknowledge bit of the launching control write picks the reply: 1 returns ACK and reports 0x50, 0 returns NACK and reports 0x58.
- R7: A start request while the bus is owned produces a repeated START and reports 0x10.
- R8: A stop request releases both lines and returns the status to 0xF8 without ever setting the flag.
- R9: During a byte, each SCL low phase lasts the low count and each high phase lasts the high count, in clock cycles.
- R10: Seeing SDA low while sending a 1 bit reports 0x38 and releases both lines. A later start request waits until the bus is free, then sends START and reports 0x08.
- R11: SDA held low for the timeout while a START waits reports 0x70 with both lines released. A following control write without the start bit returns the status to 0xF8 with the flag clear.
- R12: SCL held low for the timeout during a high phase reports 0x78 and releases SCL.
- R13: A control write while an action is in progress (flag clear, not idle) is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one timing tick |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control write strobe; launches an action and clears the flag |
| ctl_sta | input | 1 | Start request bit of the control write |
| ctl_sto | input | 1 | Stop request bit of the control write |
| ctl_aa | input | 1 | Acknowledge choice for the next received byte |
| dat_we | input | 1 | Load strobe for the shift/data register (idle or waiting only) |
| dat_wdata | input | 8 | Byte to transmit (address byte or data) |
| dat_rdata | output | 8 | Shift/data register contents; last byte seen on the bus |
| status | output | 8 | Event status code |
| si | output | 1 | Interrupt flag; set after each reported event |
| low_cnt | input | CNT_W | SCL low phase length in cycles (at least 1) |
| high_cnt | input | CNT_W | SCL high phase length in cycles (at least 1) |
| scl_i | input | 1 | Sensed SCL level |
| sda_i | input | 1 | Sensed SDA level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
Results arrive after a variable number of bus phases, so the bench never waits a fixed number of cycles. It polls the flag at falling clock edges and reads the status on the first sample where the flag is 1. The flag and the code are written by the same register edge, so that sample is valid. Phase lengths are measured as run lengths of the SCL level, sampled once per cycle, and read one cycle after the flag rises, when the acknowledge phase has closed. Stop completion is polled for 0xF8 and then watched for a further window to confirm the flag never rises. The timeout faults are expected after the timeout count, and each wait is bounded.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_SWAIT, S_SHOLD, S_RLOW, S_RHIGH,
    S_BLOW, S_BHIGH, S_PLOW, S_PHIGH, S_PEND
  } eng_st_e;

  typedef enum logic [1:0] {X_ADDR, X_TX, X_RX} xfer_ctx_e;

  localparam logic [7:0] C_IDLE    = 8'hF8;
  localparam logic [7:0] C_START   = 8'h08;
  localparam logic [7:0] C_RSTART  = 8'h10;
  localparam logic [7:0] C_AW_ACK  = 8'h18;
  localparam logic [7:0] C_AW_NACK = 8'h20;
  localparam logic [7:0] C_TX_ACK  = 8'h28;
  localparam logic [7:0] C_TX_NACK = 8'h30;
  localparam logic [7:0] C_ARB     = 8'h38;
  localparam logic [7:0] C_AR_ACK  = 8'h40;
  localparam logic [7:0] C_AR_NACK = 8'h48;
  localparam logic [7:0] C_RX_ACK  = 8'h50;
  localparam logic [7:0] C_RX_NACK = 8'h58;
  localparam logic [7:0] C_SDA_LOW = 8'h70;
  localparam logic [7:0] C_SCL_LOW = 8'h78;
endpackage

// File: rtl/i2cm_tick_cnt.sv
module i2cm_tick_cnt #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         en,
  input  logic [W-1:0] lim,
  output logic         hit
);
  logic [W-1:0] cnt;

  assign hit = en && (cnt == lim - 1'b1);

  always_ff @(posedge clk) begin
    if (rst || clr || hit) cnt <= '0;
    else if (en)           cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/i2cm_code_enc.sv
module i2cm_code_enc
  import i2cm_pkg::*;
(
  input  xfer_ctx_e   ctx,
  input  logic        rw,
  input  logic        ack,
  input  logic        aa,
  output logic [7:0]  code
);
  always_comb begin
    unique case (ctx)
      X_ADDR:  code = rw ? (ack ? C_AR_ACK : C_AR_NACK) : (ack ? C_AW_ACK : C_AW_NACK);
      X_TX:    code = ack ? C_TX_ACK : C_TX_NACK;
      default: code = aa ? C_RX_ACK : C_RX_NACK;
    endcase
  end
endmodule

// File: rtl/i2c_status_master.sv
module i2c_status_master
  import i2cm_pkg::*;
#(
  parameter int CNT_W   = 8,
  parameter int TMO_CYC = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic             ctl_sta,
  input  logic             ctl_sto,
  input  logic             ctl_aa,
  input  logic             dat_we,
  input  logic [7:0]       dat_wdata,
  output logic [7:0]       dat_rdata,
  output logic [7:0]       status,
  output logic             si,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe
);
  localparam int TMO_W = $clog2(TMO_CYC + 1);

  eng_st_e    st, st_nxt;
  xfer_ctx_e  ctx;
  logic [7:0] shreg;
  logic [3:0] bitidx;
  logic       owned, rs_flag, aa_r;

  logic ctl_go, bus_free, in_high, use_low, is_tx, lost, ack_seen, drv_nxt;
  logic ph_en, ph_clr, ph_hit, tmo_en, tmo_hit;
  logic [CNT_W-1:0] ph_lim;
  logic [7:0] enc_code;

  assign ctl_go   = ctl_we && (st == S_IDLE || st == S_HOLD);
  assign bus_free = scl_i && sda_i;
  assign in_high  = (st == S_RHIGH) || (st == S_BHIGH) || (st == S_PHIGH);
  assign use_low  = (st == S_RLOW) || (st == S_BLOW) || (st == S_PLOW);
  assign is_tx    = (ctx != X_RX);
  assign lost     = is_tx && shreg[7] && !sda_i;
  assign ack_seen = !sda_i;
  assign drv_nxt  = (bitidx == 4'd7) ? (is_tx ? 1'b0 : aa_r) : (is_tx && !shreg[6]);

  assign ph_en  = use_low || (in_high && scl_i) || (st == S_SWAIT && bus_free) ||
                  (st == S_SHOLD) || (st == S_PEND);
  assign ph_lim = use_low ? low_cnt : high_cnt;
  assign ph_clr = (st_nxt != st) || (st == S_SWAIT && !bus_free);
  assign tmo_en = (st == S_SWAIT && !bus_free) || (in_high && !scl_i);

  i2cm_tick_cnt #(.W(CNT_W)) u_phase (
    .clk(clk), .rst(rst), .clr(ph_clr), .en(ph_en), .lim(ph_lim), .hit(ph_hit));

  i2cm_tick_cnt #(.W(TMO_W)) u_tmo (
    .clk(clk), .rst(rst), .clr(!tmo_en), .en(tmo_en),
    .lim(TMO_W'(TMO_CYC)), .hit(tmo_hit));

  i2cm_code_enc u_enc (
    .ctx(ctx), .rw(shreg[0]), .ack(ack_seen), .aa(aa_r), .code(enc_code));

  always_comb begin
    st_nxt = st;
    unique case (st)
      S_IDLE:  if (ctl_go && ctl_sta) st_nxt = S_SWAIT;
      S_HOLD:  if (ctl_go) begin
                 if (ctl_sta)      st_nxt = owned ? S_RLOW : S_SWAIT;
                 else if (ctl_sto) st_nxt = owned ? S_PLOW : S_IDLE;
                 else              st_nxt = owned ? S_BLOW : S_IDLE;
               end
      S_SWAIT: if (tmo_hit) st_nxt = S_HOLD; else if (ph_hit) st_nxt = S_SHOLD;
      S_SHOLD: if (ph_hit) st_nxt = S_HOLD;
      S_RLOW:  if (ph_hit) st_nxt = S_RHIGH;
      S_RHIGH: if (tmo_hit) st_nxt = S_HOLD; else if (ph_hit) st_nxt = S_SHOLD;
      S_BLOW:  if (ph_hit) st_nxt = S_BHIGH;
      S_BHIGH: if (tmo_hit) st_nxt = S_HOLD;
               else if (ph_hit) st_nxt = (bitidx == 4'd8 || lost) ? S_HOLD : S_BLOW;
      S_PLOW:  if (ph_hit) st_nxt = S_PHIGH;
      S_PHIGH: if (tmo_hit) st_nxt = S_HOLD; else if (ph_hit) st_nxt = S_PEND;
      S_PEND:  if (ph_hit) st_nxt = S_IDLE;
      default: st_nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE; ctx <= X_ADDR; shreg <= '0; bitidx <= '0;
      owned <= 1'b0; rs_flag <= 1'b0; aa_r <= 1'b0;
      status <= C_IDLE; si <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      st <= st_nxt;
      if (dat_we && (st == S_IDLE || st == S_HOLD)) shreg <= dat_wdata;
      if (ctl_go) begin si <= 1'b0; aa_r <= ctl_aa; end
      unique case (st)
        S_IDLE: if (ctl_go && ctl_sta) rs_flag <= 1'b0;
        S_HOLD: if (ctl_go) begin
          if (ctl_sta) begin
            rs_flag <= owned;
            if (owned) sda_oe <= 1'b0;
          end else if (ctl_sto) begin
            if (owned) sda_oe <= 1'b1; else status <= C_IDLE;
          end else if (owned) begin
            bitidx <= '0;
            sda_oe <= is_tx && !shreg[7];
          end else status <= C_IDLE;
        end
        S_SWAIT, S_RHIGH, S_PHIGH: begin
          if (tmo_hit) begin
            status <= (st == S_SWAIT && scl_i) ? C_SDA_LOW : C_SCL_LOW;
            si <= 1'b1; owned <= 1'b0; scl_oe <= 1'b0; sda_oe <= 1'b0;
          end else if (ph_hit) begin
            sda_oe <= (st != S_PHIGH);
          end
        end
        S_SHOLD: if (ph_hit) begin
          scl_oe <= 1'b1; si <= 1'b1; owned <= 1'b1; ctx <= X_ADDR;
          status <= rs_flag ? C_RSTART : C_START;
        end
        S_RLOW, S_BLOW, S_PLOW: if (ph_hit) scl_oe <= 1'b0;
        S_BHIGH: begin
          if (tmo_hit) begin
            status <= C_SCL_LOW; si <= 1'b1; owned <= 1'b0;
            scl_oe <= 1'b0; sda_oe <= 1'b0;
          end else if (ph_hit) begin
            if (bitidx != 4'd8) begin
              if (lost) begin
                status <= C_ARB; si <= 1'b1; owned <= 1'b0;
                scl_oe <= 1'b0; sda_oe <= 1'b0;
              end else begin
                shreg  <= {shreg[6:0], sda_i};
                scl_oe <= 1'b1;
                sda_oe <= drv_nxt;
                bitidx <= bitidx + 1'b1;
              end
            end else begin
              scl_oe <= 1'b1; si <= 1'b1; status <= enc_code;
              if (ctx == X_ADDR && ack_seen) ctx <= shreg[0] ? X_RX : X_TX;
            end
          end
        end
        S_PEND: if (ph_hit) begin status <= C_IDLE; owned <= 1'b0; end
        default: ;
      endcase
    end
  end

  assign dat_rdata = shreg;

  p_hold_scl_r2: assert property (@(posedge clk) disable iff (rst)
    (si && status != C_ARB && status != C_SDA_LOW && status != C_SCL_LOW) |-> scl_oe);
  p_si_clear_r2: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && si) |=> !si);
  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (status == C_IDLE) |-> !si);
  p_arb_release_r10: assert property (@(posedge clk) disable iff (rst)
    (si && status == C_ARB) |-> (!scl_oe && !sda_oe));
  p_stuck_release_r11: assert property (@(posedge clk) disable iff (rst)
    (si && (status == C_SDA_LOW || status == C_SCL_LOW)) |-> (!scl_oe && !sda_oe));
  p_busy_ignore_r13: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && st == S_BHIGH && !tmo_hit && !ph_hit) |=> (st == S_BHIGH));
endmodule

// File: tb/i2c_status_master_tb_top.sv
module i2c_status_master_tb_top;
  localparam int TMO = 64;
  localparam logic [6:0] SLV = 7'h2C;

  logic clk = 0, rst = 1;
  always #2 clk = ~clk;

  logic ctl_we = 0, ctl_sta = 0, ctl_sto = 0, ctl_aa = 0, dat_we = 0;
  logic [7:0] dat_wdata = 0, dat_rdata, status;
  logic si, scl_oe, sda_oe;
  logic [7:0] low_cnt = 8'd3, high_cnt = 8'd2;
  logic force_sda = 0, force_scl = 0, s_drv = 0, slv_rst = 0;
  wire scl_line = ~(scl_oe | force_scl);
  wire sda_line = ~(sda_oe | s_drv | force_sda);

  i2c_status_master #(.CNT_W(8), .TMO_CYC(TMO)) dut_i (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_sta(ctl_sta), .ctl_sto(ctl_sto),
    .ctl_aa(ctl_aa), .dat_we(dat_we), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
    .status(status), .si(si), .low_cnt(low_cnt), .high_cnt(high_cnt),
    .scl_i(scl_line), .sda_i(sda_line), .scl_oe(scl_oe), .sda_oe(sda_oe));

  int nchk = 0, nerr = 0;

  function automatic logic [7:0] rd_byte(input int n);
    return 8'h96 + 8'(n * 27);
  endfunction

  // slave model
  logic ps_scl = 1, ps_sda = 1, s_match = 0, s_rw = 0, m_acked = 0;
  int sb_cnt = 0, s_mode = 0, s_wr_cnt = 0, s_rd_cnt = 0, wr_nack_idx = 2;
  logic [7:0] sb_sh = 0, s_tx = 0, s_adr = 0;
  logic [7:0] s_got [0:7];
  always @(negedge clk) begin
    if (slv_rst) begin s_mode = 0; s_drv = 0; sb_cnt = 0; end
    else if (ps_scl && scl_line && ps_sda && !sda_line) begin
      s_mode = 1; sb_cnt = 0; s_drv = 0; s_wr_cnt = 0; s_rd_cnt = 0;
    end else if (ps_scl && scl_line && !ps_sda && sda_line) begin
      s_mode = 0; s_drv = 0;
    end else if (!ps_scl && scl_line) begin
      if (sb_cnt < 8) sb_sh = {sb_sh[6:0], sda_line};
      else if (s_mode == 3) m_acked = !sda_line;
      sb_cnt++;
    end else if (ps_scl && !scl_line && s_mode != 0) begin
      if (sb_cnt == 8) begin
        if (s_mode == 1) begin
          s_adr = sb_sh; s_match = (sb_sh[7:1] == SLV); s_rw = sb_sh[0]; s_drv = s_match;
        end else if (s_mode == 2) begin
          s_got[s_wr_cnt[2:0]] = sb_sh; s_drv = (s_wr_cnt != wr_nack_idx); s_wr_cnt++;
        end else s_drv = 0;
      end else if (sb_cnt == 9) begin
        sb_cnt = 0; s_drv = 0;
        if (s_mode == 1) begin
          if (!s_match) s_mode = 0;
          else if (s_rw) begin s_mode = 3; s_tx = rd_byte(s_rd_cnt); s_drv = !s_tx[7]; end
          else s_mode = 2;
        end else if (s_mode == 3) begin
          if (m_acked) begin s_rd_cnt++; s_tx = rd_byte(s_rd_cnt); s_drv = !s_tx[7]; end
          else s_mode = 0;
        end
      end else if (s_mode == 3 && sb_cnt >= 1 && sb_cnt <= 7) s_drv = !s_tx[7 - sb_cnt];
    end
    ps_scl = scl_line; ps_sda = sda_line;
  end

  // SCL run-length monitor
  logic run_lvl = 1; int run_len = 0, last_low = 0, last_high = 0;
  always @(negedge clk) begin
    if (scl_line == run_lvl) run_len++;
    else begin
      if (run_lvl) last_high = run_len; else last_low = run_len;
      run_lvl = scl_line; run_len = 1;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic ctl(input logic sta, input logic sto, input logic aa);
    @(negedge clk); ctl_we = 1; ctl_sta = sta; ctl_sto = sto; ctl_aa = aa;
    @(negedge clk); ctl_we = 0; ctl_sta = 0; ctl_sto = 0; ctl_aa = 0;
  endtask

  task automatic wdat(input logic [7:0] b);
    @(negedge clk); dat_we = 1; dat_wdata = b;
    @(negedge clk); dat_we = 0;
  endtask

  task automatic wait_si(input string tag);
    int n = 0;
    while (!si && n < 3000) begin @(negedge clk); n++; end
    if (!si) begin nchk++; nerr++; $display("FAIL %s: actual=si0 expected=si1", tag); end
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (status != 8'hF8 && n < 3000) begin @(negedge clk); n++; end
    chk(tag, status, 8'hF8);
  endtask

  task automatic stop_check(input string tag);
    int seen = 0;
    ctl(0, 1, 0);
    wait_idle(tag);
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (si) seen = 1; end
    chk(tag, seen, 0);
    chk(tag, {scl_oe, sda_oe}, 0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 status", status, 8'hF8);
    chk("R1 si", si, 0);
    chk("R1 lines", {scl_oe, sda_oe}, 0);

    ctl(1, 0, 0); wait_si("R2");
    chk("R2 start code", status, 8'h08);
    repeat (20) @(negedge clk);
    chk("R2 scl held", {si, scl_oe}, 2'b11);

    wdat({SLV, 1'b0}); ctl(0, 0, 0); wait_si("R3");
    chk("R3 addr write ack", status, 8'h18);
    chk("R3 addr msb first", s_adr, {SLV, 1'b0});
    @(negedge clk);
    chk("R9 low 3", last_low, 3);
    chk("R9 high 2", last_high, 2);

    for (int i = 0; i < 3; i++) begin
      logic [7:0] v = 8'h3C + 8'(i * 77);
      wdat(v); ctl(0, 0, 0);
      if (i == 0) begin repeat (4) @(negedge clk); ctl(0, 1, 0); end
      wait_si("R4");
      if (i == 0) chk("R13 busy write ignored", status, 8'h28);
      chk("R4 data code", status, (i == 2) ? 8'h30 : 8'h28);
      chk("R4 data seen", s_got[i], v);
    end

    ctl(1, 0, 0); wait_si("R7");
    chk("R7 repeated start", status, 8'h10);
    wdat({SLV, 1'b1}); ctl(0, 0, 0); wait_si("R5");
    chk("R5 addr read ack", status, 8'h40);
    for (int i = 0; i < 3; i++) begin
      ctl(0, 0, (i < 2)); wait_si("R6");
      chk("R6 rx code", status, (i < 2) ? 8'h50 : 8'h58);
      chk("R6 rx data", dat_rdata, rd_byte(i));
    end
    stop_check("R8 stop");

    low_cnt = 8'd5; high_cnt = 8'd4;
    ctl(1, 0, 0); wait_si("R2b"); chk("R2 start b", status, 8'h08);
    wdat(8'hAA); ctl(0, 0, 0); wait_si("R3b");
    chk("R3 addr write nack", status, 8'h20);
    @(negedge clk);
    chk("R9 low 5", last_low, 5);
    chk("R9 high 4", last_high, 4);
    stop_check("R8 stop b");

    ctl(1, 0, 0); wait_si("R5b");
    wdat(8'hAB); ctl(0, 0, 0); wait_si("R5c");
    chk("R5 addr read nack", status, 8'h48);
    stop_check("R8 stop c");

    // arbitration loss
    ctl(1, 0, 0); wait_si("R10a");
    wdat(8'hFF); ctl(0, 0, 0);
    while (!scl_line) @(negedge clk);
    force_sda = 1;
    wait_si("R10");
    chk("R10 arb code", status, 8'h38);
    chk("R10 lines released", {scl_oe, sda_oe}, 0);
    ctl(1, 0, 0);
    repeat (20) @(negedge clk);
    chk("R10 start waits for free bus", {si, sda_oe}, 0);
    force_sda = 0;
    wait_si("R10b");
    chk("R10 start after free", status, 8'h08);
    stop_check("R8 stop d");

    // SDA stuck
    force_sda = 1; slv_rst = 1;
    ctl(1, 0, 0); wait_si("R11");
    chk("R11 sda stuck code", status, 8'h70);
    chk("R11 lines released", {scl_oe, sda_oe}, 0);
    force_sda = 0;
    repeat (3) @(negedge clk); slv_rst = 0;
    ctl(0, 0, 0);
    chk("R11 recover", {status, 7'b0, si}, {8'hF8, 8'h00});

    // SCL stuck
    ctl(1, 0, 0); wait_si("R12a");
    wdat({SLV, 1'b0}); ctl(0, 0, 0); wait_si("R12b");
    chk("R3 addr ack again", status, 8'h18);
    wdat(8'h5A); ctl(0, 0, 0);
    force_scl = 1;
    wait_si("R12");
    chk("R12 scl stuck code", status, 8'h78);
    chk("R12 scl released", scl_oe, 0);
    slv_rst = 1; force_scl = 0;
    repeat (3) @(negedge clk); slv_rst = 0;
    ctl(0, 0, 0);
    chk("R12 recover", status, 8'hF8);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule